// File: doc/BRIEF.md
# Synchronous Transmit RTS/CTS Sequencer

This block decides when a synchronous serial transmitter may put a frame on the line. It watches the transmit FIFO's not-empty flag, a one-cycle tick that marks each falling edge of the transmit clock, and the CTS modem input. From these it drives the RTS modem output and tells the serializer when to start shifting and when each bit period is valid. The serializer always begins a frame with its opening flag, sync pattern or preamble. The sequencer's start pulse marks that point, so no payload bit can be the first bit after RTS rises.

RTS goes high on the first transmit-clock tick at which the FIFO holds data. If CTS is already qualified at that tick, transmission starts on the same tick, so there are zero bit times between RTS and the first bit. If CTS is not qualified, RTS stays high and the sequencer waits. It starts on the first tick at which CTS is qualified. The serializer flags the last bit of the frame. One transmit clock after that bit completes, RTS drops. A new frame can only begin on a later tick. CTS can be sampled raw, through a synchronizer, or forced on.

Every state change happens on the system clock. The reset is asynchronous and active low. Pulling the channel enable low returns the block to idle on the next clock.

Top module: `sync_tx_rts_ctl`

## Requirements
- R1: After reset, rts_o, tx_en_o and start_o are all 0.
- R2: From idle, rts_o rises in the cycle after a clock edge at which txclk_fall_i, fifo_nempty_i and enable_i are all 1. It never rises without such an edge.
- R3: If CTS is qualified at the tick that raises rts_o, tx_en_o and start_o rise in the same cycle as rts_o. This gives zero bit times from RTS to the first bit.
- R4: If CTS is not qualified at that tick, rts_o stays 1 with tx_en_o at 0. Transmission starts on the first later tick at which CTS is qualified. A CTS change with no tick does not start it.
- R5: start_o is a single-cycle pulse. It is 1 exactly in the first cycle of each tx_en_o high period.
- R6: While sending, a tick with frame_last_i = 1 clears tx_en_o in the next cycle and rts_o stays 1. rts_o drops after the next tick. frame_last_i without a tick has no effect.
- R7: After rts_o drops, it stays 0 at least until the following tick, even if fifo_nempty_i is still 1. It then rises again on that tick if data is present.
- R8: With cts_force_i = 1, CTS counts as qualified whatever the level of cts_i.
- R9: With cts_async_i = 0, cts_i is used directly at the tick. With cts_async_i = 1, cts_i first passes through SYNC_STAGES flops (default 2). A CTS rise is then seen only SYNC_STAGES clocks later.
- R10: While enable_i = 0, all three outputs are 0 from the next cycle on, and ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable; when low, the block goes idle synchronously |
| txclk_fall_i | input | 1 | One-cycle tick at each falling transmit-clock edge |
| fifo_nempty_i | input | 1 | Transmit FIFO holds data |
| frame_last_i | input | 1 | Serializer is sending the last bit of the frame |
| cts_i | input | 1 | Clear-to-send, active high |
| cts_async_i | input | 1 | 1: synchronize cts_i; 0: sample it directly |
| cts_force_i | input | 1 | Treat CTS as always asserted |
| rts_o | output | 1 | Request-to-send, active high |
| tx_en_o | output | 1 | Serializer may shift a bit on each tick while high |
| start_o | output | 1 | Pulse marking the first bit (opening flag/sync/preamble) |

## Verification
On every cycle the assertions check how the outputs relate to each other. They check that tx_en_o implies rts_o and that start_o pulses once at each rise of tx_en_o. They also check that RTS moves only on qualified ticks, that a forced CTS gives a zero-delay start, and that disable clears everything. Some behaviour depends on what the inputs were over several earlier ticks, and only the bench's scenarios can show it. That covers the wait for CTS in the two sampling modes, the synchronizer latency, the one-clock hold after the last bit, and the forced gap before a back-to-back frame. The bench tracks these with a cycle model built from the requirements.

// File: rtl/sync_tx_rts_pkg.sv
package sync_tx_rts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_CTS = 2'd1,
    ST_SEND     = 2'd2,
    ST_HOLD     = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sync_tx_cts_qual.sv
module sync_tx_cts_qual #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_i,
  input  logic async_i,
  input  logic force_i,
  output logic cts_ok_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= cts_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign cts_ok_o = force_i | (async_i ? sync_q[LAST] : cts_i);
endmodule

// File: rtl/sync_tx_rts_fsm.sv
module sync_tx_rts_fsm
  import sync_tx_rts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic tick_i,
  input  logic fifo_nempty_i,
  input  logic frame_last_i,
  input  logic cts_ok_i,
  output logic rts_o,
  output logic tx_en_o,
  output logic start_o
);
  tx_state_e state_q, state_d;
  logic rts_d, tx_en_d, start_d;

  always_comb begin
    state_d = state_q;
    rts_d   = rts_o;
    tx_en_d = tx_en_o;
    start_d = 1'b0;
    if (!enable_i) begin
      state_d = ST_IDLE;
      rts_d   = 1'b0;
      tx_en_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (tick_i && fifo_nempty_i) begin
          rts_d = 1'b1;
          if (cts_ok_i) begin
            state_d = ST_SEND;
            tx_en_d = 1'b1;
            start_d = 1'b1;
          end else begin
            state_d = ST_WAIT_CTS;
          end
        end
        ST_WAIT_CTS: if (tick_i && cts_ok_i) begin
          state_d = ST_SEND;
          tx_en_d = 1'b1;
          start_d = 1'b1;
        end
        ST_SEND: if (tick_i && frame_last_i) begin
          state_d = ST_HOLD;   // keep RTS one more transmit clock
          tx_en_d = 1'b0;
        end
        ST_HOLD: if (tick_i) begin
          state_d = ST_IDLE;
          rts_d   = 1'b0;
        end
        default: begin
          state_d = ST_IDLE;
          rts_d   = 1'b0;
          tx_en_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rts_o   <= 1'b0;
      tx_en_o <= 1'b0;
      start_o <= 1'b0;
    end else begin
      state_q <= state_d;
      rts_o   <= rts_d;
      tx_en_o <= tx_en_d;
      start_o <= start_d;
    end
  end
endmodule

// File: rtl/sync_tx_rts_ctl.sv
module sync_tx_rts_ctl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic txclk_fall_i,
  input  logic fifo_nempty_i,
  input  logic frame_last_i,
  input  logic cts_i,
  input  logic cts_async_i,
  input  logic cts_force_i,
  output logic rts_o,
  output logic tx_en_o,
  output logic start_o
);
  logic cts_ok;

  sync_tx_cts_qual #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cts_i    (cts_i),
    .async_i  (cts_async_i),
    .force_i  (cts_force_i),
    .cts_ok_o (cts_ok)
  );

  sync_tx_rts_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .tick_i        (txclk_fall_i),
    .fifo_nempty_i (fifo_nempty_i),
    .frame_last_i  (frame_last_i),
    .cts_ok_i      (cts_ok),
    .rts_o         (rts_o),
    .tx_en_o       (tx_en_o),
    .start_o       (start_o)
  );
endmodule

// File: rtl/sync_tx_rts_ctl_chk.sv
module sync_tx_rts_ctl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enable_i,
  input logic txclk_fall_i,
  input logic fifo_nempty_i,
  input logic cts_force_i,
  input logic rts_o,
  input logic tx_en_o,
  input logic start_o
);
  a_r3_start_with_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (tx_en_o && rts_o));

  a_r5_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  a_r5_tx_rise_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> start_o);

  a_r6_tx_needs_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_en_o |-> rts_o);

  a_r2_rts_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rts_o) |-> $past(txclk_fall_i && fifo_nempty_i && enable_i));

  a_r6_rts_fall_after_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rts_o) && $past(enable_i)) |-> ($past(txclk_fall_i) && $past(!tx_en_o)));

  a_r8_forced_zero_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rts_o) && $past(cts_force_i)) |-> start_o);

  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!rts_o && !tx_en_o && !start_o));
endmodule

bind sync_tx_rts_ctl sync_tx_rts_ctl_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .txclk_fall_i  (txclk_fall_i),
  .fifo_nempty_i (fifo_nempty_i),
  .cts_force_i   (cts_force_i),
  .rts_o         (rts_o),
  .tx_en_o       (tx_en_o),
  .start_o       (start_o)
);

// File: tb/sync_tx_rts_ctl_tb.sv
`timescale 1ns/1ps
module sync_tx_rts_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, tick = 1'b0, fifo = 1'b0, flast = 1'b0;
  logic cts = 1'b0, casync = 1'b0, cforce = 1'b0;
  logic rts, txen, start;

  int checks = 0;
  int fails = 0;

  // reference model, from the requirements
  int   m_st = 0;           // 0 idle, 1 wait, 2 send, 3 hold
  logic m_rts = 0, m_tx = 0, m_start = 0;
  logic m_s1 = 0, m_s2 = 0;

  always #4 clk = ~clk;

  sync_tx_rts_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .txclk_fall_i(tick),
    .fifo_nempty_i(fifo), .frame_last_i(flast), .cts_i(cts),
    .cts_async_i(casync), .cts_force_i(cforce),
    .rts_o(rts), .tx_en_o(txen), .start_o(start)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string tag_of(int st, logic e);
    if (!e) return "R10";
    case (st)
      0: return "R2";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model_step();
    logic ok;
    ok = cforce | (casync ? m_s2 : cts);
    m_s2 = m_s1;
    m_s1 = cts;
    m_start = 1'b0;
    if (!en) begin
      m_st = 0; m_rts = 0; m_tx = 0;
    end else begin
      case (m_st)
        0: if (tick && fifo) begin
             m_rts = 1;
             if (ok) begin m_st = 2; m_tx = 1; m_start = 1; end
             else m_st = 1;
           end
        1: if (tick && ok) begin m_st = 2; m_tx = 1; m_start = 1; end
        2: if (tick && flast) begin m_st = 3; m_tx = 0; end
        default: if (tick) begin m_st = 0; m_rts = 0; end
      endcase
    end
  endtask

  // one clock; model advances with the inputs the DUT sampled, then compares
  task automatic cyc();
    string t;
    t = tag_of(m_st, en);
    @(posedge clk);
    @(negedge clk);
    model_step();
    chk(t, "rts_o", rts, m_rts);
    chk(t, "tx_en_o", txen, m_tx);
    chk("R5", "start_o", start, m_start);
  endtask

  task automatic tick_cyc();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rts_o after reset", rts, 1'b0);
    chk("R1", "tx_en_o after reset", txen, 1'b0);
    chk("R1", "start_o after reset", start, 1'b0);

    // R2: data present but no tick -> no RTS
    en = 1; fifo = 1; cts = 1;
    cyc(); cyc();
    chk("R2", "rts_o without tick", rts, 1'b0);

    // R3: CTS already on -> zero delay
    tick_cyc();
    chk("R3", "rts_o on tick", rts, 1'b1);
    chk("R3", "tx_en_o same cycle", txen, 1'b1);
    chk("R3", "start_o same cycle", start, 1'b1);
    cyc();
    chk("R5", "start_o second cycle", start, 1'b0);
    tick_cyc(); tick_cyc();
    // R6: last bit, frame_last without tick ignored
    flast = 1; cyc();
    chk("R6", "tx_en_o, frame_last no tick", txen, 1'b1);
    tick_cyc(); flast = 0;
    chk("R6", "tx_en_o after last bit", txen, 1'b0);
    chk("R6", "rts_o held after last bit", rts, 1'b1);
    cyc(); cyc();
    chk("R6", "rts_o before release tick", rts, 1'b1);
    tick_cyc();
    chk("R6", "rts_o released", rts, 1'b0);
    cyc();
    chk("R7", "rts_o gap with fifo data", rts, 1'b0);
    tick_cyc();
    chk("R7", "rts_o restart on next tick", rts, 1'b1);
    flast = 1; tick_cyc(); flast = 0; tick_cyc();

    // R4: CTS low -> wait
    fifo = 1; cts = 0; cyc();
    tick_cyc();
    chk("R4", "rts_o while waiting", rts, 1'b1);
    chk("R4", "tx_en_o while waiting", txen, 1'b0);
    cts = 1; cyc();
    chk("R4", "tx_en_o cts w/o tick", txen, 1'b0);
    tick_cyc();
    chk("R4", "tx_en_o start on cts tick", txen, 1'b1);
    chk("R4", "start_o on cts tick", start, 1'b1);
    flast = 1; tick_cyc(); flast = 0; tick_cyc();

    // R9: async sampling latency
    casync = 1; cts = 0; cyc(); cyc(); cyc();
    tick_cyc();
    chk("R9", "rts_o waiting async", rts, 1'b1);
    cts = 1; tick_cyc();
    chk("R9", "tx_en_o not yet synced", txen, 1'b0);
    tick_cyc();
    chk("R9", "tx_en_o one stage in", txen, 1'b0);
    tick_cyc();
    chk("R9", "tx_en_o after sync stages", txen, 1'b1);
    flast = 1; tick_cyc(); flast = 0; tick_cyc();
    cyc();
    tick_cyc();
    chk("R9", "async stable cts zero delay", start, 1'b1);
    flast = 1; tick_cyc(); flast = 0; tick_cyc();
    casync = 0;

    // R8: forced CTS
    cts = 0; cforce = 1; cyc();
    tick_cyc();
    chk("R8", "start_o with forced cts", start, 1'b1);
    // R10: disable mid-frame
    en = 0; cyc();
    chk("R10", "rts_o disabled", rts, 1'b0);
    chk("R10", "tx_en_o disabled", txen, 1'b0);
    tick_cyc();
    chk("R10", "rts_o tick while disabled", rts, 1'b0);
    en = 1; cforce = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick   = ($urandom_range(3) == 0);
      if ($urandom_range(7) == 0) fifo = ~fifo;
      if ($urandom_range(9) == 0) cts = ~cts;
      flast  = m_tx && ($urandom_range(2) == 0);
      en     = ($urandom_range(99) != 0);
      if ($urandom_range(199) == 0) cforce = ~cforce;
      if ($urandom_range(149) == 0) casync = ~casync;
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule